// File: doc/BRIEF.md
# Seconds Ring Counter

This block counts seconds from 00 to 59. It counts up or down and wraps at both ends. The count is held as a tens digit and a units digit in BCD. Logic after the digit registers turns that value straight into the drive pattern for a ring of sixty LEDs, so no separate code-conversion stage is needed downstream.

The ring has two display styles, picked by a mode pin. In the dot style one LED is lit at the position of the current count. In the bar style every LED from position 0 up to the count is lit, so the ring fills as the minute goes by. The LED drive is active low. A blanking pin turns the whole ring off without touching the count, which lets a controller flash the ring while time is being set.

A terminal-count pin is high when the next enabled edge will wrap the counter. A larger time-of-day counter can use it to step the next section. Every pin is a plain control or status level. The block has no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `sec_ring_counter`

## Requirements
- R1: When `cnt_en` is high and `dn_sel` is low, each rising clock edge adds one to the count, and 59 goes to 00.
- R2: When `cnt_en` is high and `dn_sel` is high, each rising clock edge subtracts one from the count, and 00 goes to 59.
- R3: When `cnt_en` is low, the count does not change.
- R4: When `rst` is high at a rising clock edge, the count becomes 00. This reset is synchronous and takes priority over counting.
- R5: `bcd_tens` (0 to 5) and `bcd_units` (0 to 9) always show the count as two BCD digits, so that count = 10*tens + units.
- R6: When `fill_mode` = 0 (dot style) and `blank` is low, `led_n[n]` is 0 for the current count n and every other bit is 1. Bit i of `led_n` drives ring position i.
- R7: When `fill_mode` = 1 (bar style) and `blank` is low, `led_n[i]` is 0 for every i from 0 to n and 1 above n. At 59 all sixty bits are 0, and after a wrap to 00 only bit 0 is 0.
- R8: When `blank` is high, all sixty bits of `led_n` are 1, whatever the count and the mode.
- R9: `tc` is high exactly when `cnt_en` is high and either the count is 59 with `dn_sel` low, or the count is 00 with `dn_sel` high.
- R10: `blank` and `fill_mode` change only the LED outputs and never affect the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable |
| dn_sel | input | 1 | Direction: 0 counts up, 1 counts down |
| fill_mode | input | 1 | Ring style: 0 dot, 1 bar |
| blank | input | 1 | Turns every LED off |
| led_n | output | 60 | Active-low ring drive, bit i is position i |
| bcd_units | output | 4 | Units digit of the count, BCD |
| bcd_tens | output | 4 | Tens digit of the count, BCD |
| tc | output | 1 | Terminal count for chaining |

## Verification
- **Full up sweep:** the counter runs one full minute upward, past the 59-to-00 wrap, in dot style. This shows whether the units digit carries into the tens digit at every decade, and whether `tc` rises only at 59.
- **Full down sweep:** the mirror of the up sweep. It exposes a borrow that misses the 10-to-09 step, or a down wrap that lands somewhere other than 59.
- **Bar-style pass:** it covers positions 0, a decade boundary, 59 and the wrap back to 0. This separates a less-than compare from a less-or-equal compare in the fill.
- **Blank and mode toggling:** `blank` and `fill_mode` are switched while the counter runs and while it holds. This shows that the display path never feeds back into the count.

// File: rtl/sring_pkg.sv
package sring_pkg;

  // Two-digit BCD value of the seconds count.
  typedef struct packed {
    logic [3:0] tens;
    logic [3:0] units;
  } bcd_pair_t;

  // Ring display style.
  typedef enum logic {
    STYLE_DOT = 1'b0,
    STYLE_BAR = 1'b1
  } ring_style_e;

  // Convert a BCD pair to a binary position.
  function automatic logic [7:0] bcd_to_bin(bcd_pair_t v);
    logic [7:0] t8;
    t8 = {4'd0, v.tens};
    return (t8 << 3) + (t8 << 1) + {4'd0, v.units};
  endfunction

endpackage

// File: rtl/sring_count_core.sv
module sring_count_core
  import sring_pkg::*;
#(
  parameter int MODULUS = 60
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      dn,
  output bcd_pair_t val,
  output logic      at_top,
  output logic      at_zero
);
  localparam int TOP_TENS  = (MODULUS - 1) / 10;
  localparam int TOP_UNITS = (MODULUS - 1) % 10;
  localparam bcd_pair_t TOP_VAL  = '{tens: 4'(TOP_TENS), units: 4'(TOP_UNITS)};
  localparam bcd_pair_t ZERO_VAL = '{tens: 4'd0, units: 4'd0};

  bcd_pair_t nxt;

  assign at_top  = (val == TOP_VAL);
  assign at_zero = (val == ZERO_VAL);

  always_comb begin
    nxt = val;
    if (en) begin
      if (dn) begin
        if (at_zero)              nxt = TOP_VAL;
        else if (val.units == 4'd0) begin
          nxt.tens  = val.tens - 4'd1;
          nxt.units = 4'd9;
        end else                  nxt.units = val.units - 4'd1;
      end else begin
        if (at_top)               nxt = ZERO_VAL;
        else if (val.units == 4'd9) begin
          nxt.tens  = val.tens + 4'd1;
          nxt.units = 4'd0;
        end else                  nxt.units = val.units + 4'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) val <= ZERO_VAL;
    else     val <= nxt;
  end
endmodule

// File: rtl/sring_pos_conv.sv
module sring_pos_conv
  import sring_pkg::*;
#(
  parameter int IW = 6
) (
  input  bcd_pair_t     val,
  output logic [IW-1:0] pos
);
  logic [7:0] wide;
  assign wide = bcd_to_bin(val);
  assign pos  = wide[IW-1:0];
endmodule

// File: rtl/sring_led_decode.sv
module sring_led_decode #(
  parameter int N  = 60,
  parameter int IW = 6
) (
  input  logic [IW-1:0] pos,
  input  logic          bar_style,
  input  logic          blank,
  output logic [N-1:0]  led_n
);
  for (genvar i = 0; i < N; i++) begin : g_led
    localparam logic [IW-1:0] MY_POS = IW'(i);
    logic lit;
    assign lit      = bar_style ? (MY_POS <= pos) : (MY_POS == pos);
    assign led_n[i] = blank | ~lit;
  end
endmodule

// File: rtl/sec_ring_counter.sv
module sec_ring_counter
  import sring_pkg::*;
#(
  parameter int RING_LEN = 60
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cnt_en,
  input  logic                dn_sel,
  input  logic                fill_mode,
  input  logic                blank,
  output logic [RING_LEN-1:0] led_n,
  output logic [3:0]          bcd_units,
  output logic [3:0]          bcd_tens,
  output logic                tc
);
  localparam int IW = $clog2(RING_LEN);

  bcd_pair_t     cnt;
  logic          at_top, at_zero;
  logic [IW-1:0] pos;

  sring_count_core #(.MODULUS(RING_LEN)) u_core (
    .clk(clk), .rst(rst), .en(cnt_en), .dn(dn_sel),
    .val(cnt), .at_top(at_top), .at_zero(at_zero)
  );

  sring_pos_conv #(.IW(IW)) u_pos (.val(cnt), .pos(pos));

  sring_led_decode #(.N(RING_LEN), .IW(IW)) u_dec (
    .pos(pos), .bar_style(fill_mode == STYLE_BAR), .blank(blank), .led_n(led_n)
  );

  assign bcd_units = cnt.units;
  assign bcd_tens  = cnt.tens;
  assign tc        = cnt_en & (dn_sel ? at_zero : at_top);
endmodule

// File: rtl/sring_checker.sv
module sring_checker #(
  parameter int RING_LEN = 60
) (
  input logic                clk,
  input logic                rst,
  input logic                cnt_en,
  input logic                dn_sel,
  input logic                fill_mode,
  input logic                blank,
  input logic [RING_LEN-1:0] led_n,
  input logic [3:0]          bcd_units,
  input logic [3:0]          bcd_tens,
  input logic                tc
);
  int idx;
  assign idx = int'(bcd_tens) * 10 + int'(bcd_units);

  // R4
  reset_zero_chk: assert property (@(posedge clk) rst |=> (idx == 0));

  // R1
  up_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !dn_sel) |=> idx == (($past(idx) == RING_LEN - 1) ? 0 : $past(idx) + 1));

  // R2
  down_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && dn_sel) |=> idx == (($past(idx) == 0) ? RING_LEN - 1 : $past(idx) - 1));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(idx));

  // R5
  bcd_range_chk: assert property (@(posedge clk) disable iff (rst)
    (bcd_units <= 4'd9) && (idx < RING_LEN));

  // R6
  dot_single_chk: assert property (@(posedge clk) disable iff (rst)
    (!blank && !fill_mode) |-> ($countones(~led_n) == 1) && !led_n[idx]);

  // R7
  bar_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (!blank && fill_mode) |-> ($countones(~led_n) == idx + 1) && !led_n[0]);

  // R8
  blank_dark_chk: assert property (@(posedge clk) disable iff (rst)
    blank |-> (&led_n));

  // R9
  tc_enable_chk: assert property (@(posedge clk) disable iff (rst)
    tc |-> (cnt_en && (dn_sel ? idx == 0 : idx == RING_LEN - 1)));
endmodule

bind sec_ring_counter sring_checker #(.RING_LEN(RING_LEN)) u_sring_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .dn_sel(dn_sel), .fill_mode(fill_mode),
  .blank(blank), .led_n(led_n), .bcd_units(bcd_units), .bcd_tens(bcd_tens), .tc(tc)
);

// File: tb/sec_ring_counter_bench.sv
module sec_ring_counter_bench;
  logic        clk = 1'b0;
  logic        rst, cnt_en, dn_sel, fill_mode, blank;
  logic [59:0] led_n;
  logic [3:0]  bcd_units, bcd_tens;
  logic        tc;

  int n_checks = 0;
  int n_fail   = 0;
  int model    = 0;

  always #2 clk = ~clk;

  sec_ring_counter u_sec_ring_counter (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .dn_sel(dn_sel), .fill_mode(fill_mode),
    .blank(blank), .led_n(led_n), .bcd_units(bcd_units), .bcd_tens(bcd_tens), .tc(tc)
  );

  function automatic logic [59:0] exp_led(int n, logic bar, logic blk);
    logic [59:0] v;
    for (int i = 0; i < 60; i++)
      v[i] = blk ? 1'b1 : (bar ? !(i <= n) : !(i == n));
    return v;
  endfunction

  task automatic check(string req);
    logic [59:0] el;
    logic        etc;
    el  = exp_led(model, fill_mode, blank);
    etc = cnt_en && (dn_sel ? model == 0 : model == 59);
    n_checks++;
    if (bcd_tens != 4'(model / 10) || bcd_units != 4'(model % 10)) begin
      n_fail++;
      $display("FAIL %s: bcd %0d%0d expected %0d", req, bcd_tens, bcd_units, model);
    end
    if (led_n !== el) begin
      n_fail++;
      $display("FAIL %s: led_n %h expected %h", req, led_n, el);
    end
    if (tc !== etc) begin
      n_fail++;
      $display("FAIL %s: tc %0b expected %0b", req, tc, etc);
    end
  endtask

  // One clock with the given inputs; the model follows the requirements.
  task automatic step(logic en, logic dn);
    cnt_en = en;
    dn_sel = dn;
    @(posedge clk);
    if (rst)     model = 0;
    else if (en) model = dn ? (model == 0 ? 59 : model - 1) : (model == 59 ? 0 : model + 1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; blank = 1'b0; fill_mode = 1'b0;
    step(1'b1, 1'b0);
    check("R4");
    rst = 1'b0;
    check("R5");
  endtask

  task automatic t_up_sweep();
    fill_mode = 1'b0; blank = 1'b0;
    for (int k = 0; k < 62; k++) begin
      cnt_en = 1'b1; dn_sel = 1'b0;
      check(model == 59 ? "R9" : "R6");
      step(1'b1, 1'b0);
      check(model == 0 ? "R1" : "R5");
    end
  endtask

  task automatic t_down_sweep();
    for (int k = 0; k < 62; k++) begin
      cnt_en = 1'b1; dn_sel = 1'b1;
      check(model == 0 ? "R9" : "R6");
      step(1'b1, 1'b1);
      check(model == 59 ? "R2" : "R5");
    end
  endtask

  task automatic t_hold();
    for (int k = 0; k < 5; k++) begin
      step(1'b0, k[0]);
      check("R3");
    end
  endtask

  task automatic t_bar();
    fill_mode = 1'b1;
    rst = 1'b1; step(1'b0, 1'b0); rst = 1'b0;
    check("R7");
    for (int k = 0; k < 61; k++) begin
      step(1'b1, 1'b0);
      if (model == 9 || model == 10 || model == 59 || model == 0) check("R7");
    end
  endtask

  task automatic t_blank_and_mode();
    blank = 1'b1;
    for (int k = 0; k < 7; k++) begin
      fill_mode = k[0];
      step(1'b1, 1'b0);
      check("R8");
    end
    for (int k = 0; k < 4; k++) begin
      blank = k[0]; fill_mode = k[1];
      step(1'b0, 1'b0);
      check("R10");
    end
    blank = 1'b0;
    step(1'b1, 1'b1);
    check("R10");
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: run not finished, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; cnt_en = 1'b0; dn_sel = 1'b0; fill_mode = 1'b0; blank = 1'b0;
    @(negedge clk);
    t_reset();
    t_up_sweep();
    t_down_sweep();
    t_hold();
    t_bar();
    t_blank_and_mode();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule